// File: doc/BRIEF.md
# Two-Beam Infrared Obstacle Scanner

This block drives a proximity sensor built from two infrared emitters, one aimed left and one aimed right, that share a single receiver placed between them. The receiver responds only to light modulated at about 38 kHz. The block makes that carrier from the system clock and lights only one emitter at a time. Any echo the receiver reports can therefore be credited to the side that was lit.

A scan has four phases in a fixed order: left lit, dark gap, right lit, dark gap. The gaps give the receiver time to recover before the other side is lit. The receiver line is active low and is synchronised into the clock domain. A side counts as seeing an obstacle when the line stays low for a minimum run of consecutive cycles inside that side's lit window.

At the end of each full scan the block publishes three registered flags together: left, right and front. An echo from both sides is reported as an obstacle straight ahead.

Top module: `irscan_top`

## Requirements
- R1: The carrier is a square wave with a 50% duty cycle. Its half period is HALF = CLK_HZ/(2*CARRIER_HZ) clocks (50 clocks by default). In each lit window of ON_CYCLES clocks, the lit emitter shows ON_CYCLES/(2*HALF) rising edges and is high for ON_CYCLES/2 clocks.
- R2: Phases repeat in the order left-lit (ON_CYCLES clocks), left-gap (GAP_CYCLES), right-lit (ON_CYCLES), right-gap (GAP_CYCLES). emit_left toggles only in the left-lit window and emit_right only in the right-lit window, and both are never high together. The emitter outputs are registered, so each lags the phase by one clock.
- R3: Both emitter outputs stay low during the two gap phases and while rst is high.
- R4: rx_n is active low and passes through two synchroniser stages. A side is marked detected only if MIN_LOW consecutive low cycles (64 by default) fall inside that side's lit window. A run of MIN_LOW-1 cycles, or a run broken by a single high cycle, is ignored.
- R5: Receiver lows seen during either gap phase have no effect on the flags.
- R6: The flag encoding is {obs_front, obs_right, obs_left}. Left side only gives 001, right side only gives 010, both sides give 100, and neither side gives 000. At most one flag is ever high.
- R7: All three flags change together, and only at the last clock of the right-gap phase. In every other clock they hold the result of the previous scan.
- R8: A synchronous active-high reset clears the flags and restarts the scan at the first clock of the left-lit phase. The first scan after reset is classified normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_n | input | 1 | Receiver output, low while a modulated echo is received |
| emit_left | output | 1 | Carrier drive for the left emitter |
| emit_right | output | 1 | Carrier drive for the right emitter |
| obs_left | output | 1 | Obstacle seen by the left beam only |
| obs_right | output | 1 | Obstacle seen by the right beam only |
| obs_front | output | 1 | Obstacle seen by both beams |

## Verification
Two things happen in the same clock at the last cycle of the right gap: the flags take the new classification, and both side detectors clear their hit latches for the next scan. The bench runs scans back to back and alternates strong echoes, threshold-length echoes and no echo. If a latch were not cleared, or were cleared one cycle early, the next scan's flags would be wrong. The bench also checks, in the middle of each scan, that the flags still hold the previous scan's result. A reset applied in the middle of a scan, with the flags set to front, must clear the flags. The scan that follows must then line up again with the left window.

// File: rtl/irscan_pkg.sv
package irscan_pkg;

    typedef enum logic [1:0] {
        PH_LEFT_ON   = 2'd0,
        PH_LEFT_GAP  = 2'd1,
        PH_RIGHT_ON  = 2'd2,
        PH_RIGHT_GAP = 2'd3
    } scan_phase_e;

    typedef struct packed {
        logic front;
        logic right;
        logic left;
    } obst_t;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_L    = 0;
    localparam int unsigned SIDE_R    = 1;

    function automatic int unsigned half_period(input int unsigned clk_hz,
                                                input int unsigned carrier_hz);
        int unsigned h;
        h = clk_hz / (2 * carrier_hz);
        return (h < 1) ? 1 : h;
    endfunction

    function automatic scan_phase_e next_phase(input scan_phase_e p);
        case (p)
            PH_LEFT_ON:  return PH_LEFT_GAP;
            PH_LEFT_GAP: return PH_RIGHT_ON;
            PH_RIGHT_ON: return PH_RIGHT_GAP;
            default:     return PH_LEFT_ON;
        endcase
    endfunction

    function automatic logic is_lit(input scan_phase_e p);
        return (p == PH_LEFT_ON) || (p == PH_RIGHT_ON);
    endfunction

    function automatic logic [NUM_SIDES-1:0] side_window(input scan_phase_e p);
        logic [NUM_SIDES-1:0] w;
        w = '0;
        w[SIDE_L] = (p == PH_LEFT_ON);
        w[SIDE_R] = (p == PH_RIGHT_ON);
        return w;
    endfunction

    function automatic obst_t classify(input logic [NUM_SIDES-1:0] hits);
        obst_t o;
        o.front = hits[SIDE_L] &  hits[SIDE_R];
        o.left  = hits[SIDE_L] & ~hits[SIDE_R];
        o.right = hits[SIDE_R] & ~hits[SIDE_L];
        return o;
    endfunction

endpackage

// File: rtl/irscan_sync.sv
module irscan_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irscan_carrier.sv
module irscan_carrier #(
    parameter int unsigned HALF = 50
) (
    input  logic clk,
    input  logic rst,
    output logic carrier
);
    localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

    logic [DIV_W-1:0] div_q;
    logic             car_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            car_q <= 1'b0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            car_q <= ~car_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign carrier = car_q;
endmodule

// File: rtl/irscan_sequencer.sv
module irscan_sequencer
    import irscan_pkg::*;
#(
    parameter int unsigned ON_CYCLES  = 400,
    parameter int unsigned GAP_CYCLES = 100
) (
    input  logic        clk,
    input  logic        rst,
    output scan_phase_e phase,
    output logic        scan_end
);
    localparam int unsigned LONGEST = (ON_CYCLES > GAP_CYCLES) ? ON_CYCLES : GAP_CYCLES;
    localparam int unsigned CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYCLES - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

    scan_phase_e      phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             wrap;

    always_comb begin
        last_cnt = is_lit(phase_q) ? ON_LAST : GAP_LAST;
        wrap     = (cnt_q == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LEFT_ON;
            cnt_q   <= '0;
        end else if (wrap) begin
            phase_q <= next_phase(phase_q);
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase    = phase_q;
    assign scan_end = wrap && (phase_q == PH_RIGHT_GAP);
endmodule

// File: rtl/irscan_side_det.sv
module irscan_side_det #(
    parameter int unsigned MIN_LOW = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic win,
    input  logic rx_low,
    input  logic clear,
    output logic hit
);
    localparam int unsigned RUN_W = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_LOW - 1);

    logic [RUN_W-1:0] run_q;
    logic             hit_q;
    logic             echo;

    assign echo = win && rx_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (echo) begin
            if (run_q != RUN_LAST) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                            hit_q <= 1'b0;
        else if (clear)                     hit_q <= 1'b0;
        else if (echo && run_q == RUN_LAST) hit_q <= 1'b1;
    end

    assign hit = hit_q;
endmodule

// File: rtl/irscan_top.sv
module irscan_top
    import irscan_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 3_800_000,
    parameter int unsigned CARRIER_HZ  = 38_000,
    parameter int unsigned ON_CYCLES   = 400,
    parameter int unsigned GAP_CYCLES  = 100,
    parameter int unsigned MIN_LOW     = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_n,
    output logic emit_left,
    output logic emit_right,
    output logic obs_left,
    output logic obs_right,
    output logic obs_front
);
    localparam int unsigned HALF = half_period(CLK_HZ, CARRIER_HZ);

    scan_phase_e          phase;
    logic                 scan_end;
    logic                 carrier;
    logic                 rx_sync;
    logic [NUM_SIDES-1:0] side_win;
    logic [NUM_SIDES-1:0] side_hit;
    logic [NUM_SIDES-1:0] emit_q;
    obst_t                flags_q;

    irscan_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(rx_n), .q(rx_sync)
    );

    irscan_carrier #(.HALF(HALF)) u_carrier (
        .clk(clk), .rst(rst), .carrier(carrier)
    );

    irscan_sequencer #(.ON_CYCLES(ON_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .phase(phase), .scan_end(scan_end)
    );

    assign side_win = side_window(phase);

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            irscan_side_det #(.MIN_LOW(MIN_LOW)) u_det (
                .clk(clk), .rst(rst), .win(side_win[s]), .rx_low(~rx_sync),
                .clear(scan_end), .hit(side_hit[s])
            );

            always_ff @(posedge clk) begin
                if (rst) emit_q[s] <= 1'b0;
                else     emit_q[s] <= carrier & side_win[s];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)           flags_q <= '0;
        else if (scan_end) flags_q <= classify(side_hit);
    end

    assign emit_left  = emit_q[SIDE_L];
    assign emit_right = emit_q[SIDE_R];
    assign obs_left   = flags_q.left;
    assign obs_right  = flags_q.right;
    assign obs_front  = flags_q.front;
endmodule

// File: rtl/irscan_checker.sv
module irscan_checker
    import irscan_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase,
    input logic       scan_end,
    input logic       emit_left,
    input logic       emit_right,
    input logic       obs_left,
    input logic       obs_right,
    input logic       obs_front
);
    AST_ONE_EMITTER: assert property (@(posedge clk) disable iff (rst)
        !(emit_left && emit_right));                                          // R2

    AST_LEFT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        emit_left |-> ($past(phase) == 2'(PH_LEFT_ON)));                      // R2

    AST_RIGHT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        emit_right |-> ($past(phase) == 2'(PH_RIGHT_ON)));                    // R2

    AST_GAP_DARK: assert property (@(posedge clk) disable iff (rst)
        (($past(phase) == 2'(PH_LEFT_GAP)) || ($past(phase) == 2'(PH_RIGHT_GAP)))
        |-> (!emit_left && !emit_right));                                      // R3

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({obs_front, obs_right, obs_left}));                          // R6

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !scan_end |=> $stable({obs_front, obs_right, obs_left}));              // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!emit_left && !emit_right && !obs_left && !obs_right && !obs_front)); // R8
endmodule

bind irscan_top irscan_checker u_chk (
    .clk(clk), .rst(rst), .phase(phase), .scan_end(scan_end),
    .emit_left(emit_left), .emit_right(emit_right),
    .obs_left(obs_left), .obs_right(obs_right), .obs_front(obs_front)
);

// File: tb/irscan_top_bench.sv
module irscan_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ON   = 400;
    localparam int GAP  = 100;
    localparam int MINL = 64;
    localparam int HALF = 50;
    localparam int SCAN = 2 * (ON + GAP);
    localparam int L_START  = 100;
    localparam int R_START  = ON + GAP + 100;
    localparam int LG_START = ON + 2;
    localparam int RG_START = 2 * ON + GAP + 2;
    localparam int GAP_LEN  = 78;
    localparam int NVEC = 13;

    // {left_len, right_len, gap_low, split, expected {front,right,left}}
    localparam logic [24:0] VEC [NVEC] = '{
        {10'd0,   10'd0,   1'b0, 1'b0, 3'b000},
        {10'd200, 10'd0,   1'b0, 1'b0, 3'b001},
        {10'd0,   10'd200, 1'b0, 1'b0, 3'b010},
        {10'd200, 10'd200, 1'b0, 1'b0, 3'b100},
        {10'd64,  10'd0,   1'b0, 1'b0, 3'b001},
        {10'd63,  10'd0,   1'b0, 1'b0, 3'b000},
        {10'd0,   10'd64,  1'b0, 1'b0, 3'b010},
        {10'd0,   10'd63,  1'b0, 1'b0, 3'b000},
        {10'd64,  10'd64,  1'b0, 1'b0, 3'b100},
        {10'd0,   10'd0,   1'b1, 1'b0, 3'b000},
        {10'd0,   10'd0,   1'b0, 1'b1, 3'b000},
        {10'd250, 10'd63,  1'b0, 1'b0, 3'b001},
        {10'd200, 10'd200, 1'b0, 1'b0, 3'b100}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_n = 1'b1;
    logic emit_left, emit_right, obs_left, obs_right, obs_front;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    irscan_top u_irscan_top (
        .clk(clk), .rst(rst), .rx_n(rx_n),
        .emit_left(emit_left), .emit_right(emit_right),
        .obs_left(obs_left), .obs_right(obs_right), .obs_front(obs_front)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2, 3, 12: return "R6";
            9:              return "R5";
            default:        return "R4";
        endcase
    endfunction

    task automatic check_val(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_scan(input int llen, input int rlen, input bit gap_low, input bit split,
                            input logic [2:0] exp, input logic [2:0] prev,
                            input string tag, input bit do_carrier);
        int  rise_l = 0, rise_r = 0, hi_l = 0, hi_r = 0, wrong = 0, dark_bad = 0;
        logic pl = 1'b0, pr = 1'b0;
        for (int pos = 0; pos < SCAN; pos++) begin
            logic lo;
            lo = 1'b0;
            if (pos >= L_START && pos < L_START + llen) lo = 1'b1;
            if (pos >= R_START && pos < R_START + rlen) lo = 1'b1;
            if (split && ((pos >= L_START && pos < L_START + MINL - 24) ||
                          (pos >= L_START + MINL - 23 && pos < L_START + 2*MINL - 47))) lo = 1'b1;
            if (gap_low && ((pos >= LG_START && pos < LG_START + GAP_LEN) ||
                            (pos >= RG_START && pos < RG_START + GAP_LEN))) lo = 1'b1;
            rx_n = ~lo;
            @(negedge clk);
            if (pos < ON + GAP) begin
                if (emit_right) wrong++;
                if (emit_left) hi_l++;
                if (emit_left && !pl) rise_l++;
            end else begin
                if (emit_left) wrong++;
                if (emit_right) hi_r++;
                if (emit_right && !pr) rise_r++;
            end
            if ((pos >= ON + 1 && pos < ON + GAP) || (pos >= SCAN - GAP + 1))
                if (emit_left || emit_right) dark_bad++;
            pl = emit_left;
            pr = emit_right;
            if (pos == ON + GAP / 2)
                check_val("R7", "flags held mid-scan", int'({obs_front, obs_right, obs_left}), int'(prev));
        end
        check_val(tag, "flags at scan end", int'({obs_front, obs_right, obs_left}), int'(exp));
        if (do_carrier) begin
            check_val("R1", "left carrier rises", rise_l, ON / (2 * HALF));
            check_val("R1", "left carrier high clocks", hi_l, ON / 2);
            check_val("R1", "right carrier rises", rise_r, ON / (2 * HALF));
            check_val("R1", "right carrier high clocks", hi_r, ON / 2);
            check_val("R2", "emitter outside own window", wrong, 0);
            check_val("R3", "emitter active in gap", dark_bad, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2:0] prev;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check_val("R8", "flags in reset", int'({obs_front, obs_right, obs_left}), 0);
        check_val("R3", "emitters in reset", int'({emit_left, emit_right}), 0);
        rst = 1'b0;
        prev = 3'b000;
        for (int i = 0; i < NVEC; i++) begin
            run_scan(int'(VEC[i][24:15]), int'(VEC[i][14:5]), VEC[i][4], VEC[i][3],
                     VEC[i][2:0], prev, vec_tag(i), (i == 0));
            prev = VEC[i][2:0];
        end
        // reset in the middle of a scan while front is reported
        rx_n = 1'b0;
        repeat (250) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_val("R8", "flags after mid-scan reset", int'({obs_front, obs_right, obs_left}), 0);
        check_val("R3", "emitters during reset", int'({emit_left, emit_right}), 0);
        rst = 1'b0;
        run_scan(200, 0, 1'b0, 1'b0, 3'b001, 3'b000, "R8", 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule